// File: doc/BRIEF.md
# Status Register Write Protector

This block keeps the eight-bit status byte of a serial non-volatile memory and answers two questions for the command logic around it: may the array location at a given address be programmed, and may the status byte itself be rewritten. The status byte carries a protect-pin enable flag, a two-bit zone selector that marks part of the address space as read-only, a write-enable latch and a busy indication that mirrors an external write-in-progress input.

The command decoder drives single-cycle strobes: one to set the write-enable latch, one to clear it, one to request a status write together with the new value, and one to report that an array write has completed. A separate address input is decoded against the zone selector to raise a locked flag. The external active-low protect pin, when enabled by the status byte, blocks status writes. The non-volatile bits are modelled as ordinary registers with a synchronous active-low reset; serial framing and program-cycle timing belong to neighbouring blocks.

Top module: `status_guard`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge) the enable flag, the zone selector and the write-enable latch are 0, so status_o equals {7'b0, busy_i}, sr_wr_ok_o is 0 and addr_locked_o is 0.
- R2: status_o is laid out as bit 0 = busy_i (combinational, readable at any time including while busy), bit 1 = write-enable latch, bit 2 = zone bit 0, bit 3 = zone bit 1, bits 6:4 = 0, bit 7 = protect-pin enable.
- R3: A wel_set_i pulse sets the write-enable latch at the next edge; a wel_clr_i pulse clears it; when a set and any clearing event fall in the same cycle, the latch ends up 0.
- R4: The write-enable latch is cleared at the next edge by a wr_done_i pulse and by any accepted status write.
- R5: An accepted status write (sr_wr_i high while sr_wr_ok_o is 1) loads bit 7 and bits 3:2 of sr_wdata_i into the enable flag and zone selector at the next edge; data bits 6:4, 1 and 0 are ignored.
- R6: addr_locked_o is 1 when the zone selector is 2'b11 (any address), 2'b10 and chk_addr_i is in the upper half (address MSB 1), 2'b01 and chk_addr_i is in the upper quarter (two MSBs 11); it is 0 for zone 2'b00. With the default 11-bit address the edges are 0x400 and 0x600.
- R7: sr_wr_ok_o is 1 exactly when the write-enable latch is 1 and the pin lock is off, the pin lock being (enable flag = 1 and wp_n_i = 0).
- R8: A status write requested while sr_wr_ok_o is 0 changes no bit of the status byte, including the write-enable latch.
- R9: While the enable flag is 0, the level of wp_n_i has no effect on sr_wr_ok_o or on whether a status write is accepted.
- R10: While busy_i is 1 the pin lock is held at the value it had in the cycle before busy_i rose, so a wp_n_i change during a running write does not change sr_wr_ok_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wel_set_i | input | 1 | Set the write-enable latch |
| wel_clr_i | input | 1 | Clear the write-enable latch |
| sr_wr_i | input | 1 | Status write request |
| sr_wdata_i | input | 8 | Value offered for the status write |
| busy_i | input | 1 | Write-in-progress from the program sequencer |
| wp_n_i | input | 1 | Active-low protect pin |
| chk_addr_i | input | ADDR_W | Array address to test against the zone |
| wr_done_i | input | 1 | Array write completed |
| status_o | output | 8 | Status byte for readout |
| addr_locked_o | output | 1 | chk_addr_i lies in the protected zone |
| sr_wr_ok_o | output | 1 | A status write would be accepted now |

## Verification
The bench aims at the exact zone edges (0x3FF/0x400 and 0x5FF/0x600); a decoder with an off-by-one or swapped selector codes would flag the wrong side. It requests status writes with the pin low and the enable flag set, where a design that forgot to keep the latch would silently clear it or load new zone bits, and with the enable flag clear, where a design that ignored the enable would refuse. It collides set and clear strobes and checks that clearing wins, and it drops the pin during a busy period, where an unfrozen lock would withdraw permission mid-cycle. Long random traffic is compared against a behavioural model on every clock.

// File: rtl/sg_pkg.sv
// Shared definitions for the status write protector: bit positions of the
// status byte and the encoding of the two-bit protect-zone selector.
// Assumes an 8-bit status byte; positions are fixed by the readout layout.
package sg_pkg;

    localparam int STAT_W   = 8;
    localparam int POS_BUSY = 0;
    localparam int POS_WEL  = 1;
    localparam int POS_Z0   = 2;
    localparam int POS_Z1   = 3;
    localparam int POS_PEN  = 7;

    typedef enum logic [1:0] {
        ZONE_NONE    = 2'b00,
        ZONE_QUARTER = 2'b01,
        ZONE_HALF    = 2'b10,
        ZONE_ALL     = 2'b11
    } zone_e;

    // Assemble the readout byte; unused bits read as zero.
    function automatic logic [STAT_W-1:0] pack_status(
        input logic  pen,
        input zone_e zone,
        input logic  wel,
        input logic  busy
    );
        logic [STAT_W-1:0] b;
        b           = '0;
        b[POS_PEN]  = pen;
        b[POS_Z1]   = zone[1];
        b[POS_Z0]   = zone[0];
        b[POS_WEL]  = wel;
        b[POS_BUSY] = busy;
        return b;
    endfunction

endpackage

// File: rtl/sg_enable_latch.sv
// Write-enable latch. Set by a set strobe, cleared by any clear event.
// Assumes strobes are single-cycle; a clear in the same cycle as a set wins.
module sg_enable_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);

    logic wel_q;

    // Latch update: reset and clear dominate, then set, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     wel_q <= 1'b0;
        else if (clr_i) wel_q <= 1'b0;
        else if (set_i) wel_q <= 1'b1;
    end

    assign wel_o = wel_q;

endmodule

// File: rtl/sg_status_regs.sv
// Writable part of the status byte: protect-pin enable flag and zone selector.
// Assumes wr_en_i is already qualified by the permission logic; bits of the
// offered value outside those fields are dropped here.
module sg_status_regs
    import sg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [STAT_W-1:0] wdata_i,
    output logic              pen_o,
    output zone_e             zone_o
);

    logic  pen_q;
    zone_e zone_q;

    // Load the enable flag and zone selector on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_q  <= 1'b0;
            zone_q <= ZONE_NONE;
        end else if (wr_en_i) begin
            pen_q  <= wdata_i[POS_PEN];
            zone_q <= zone_e'({wdata_i[POS_Z1], wdata_i[POS_Z0]});
        end
    end

    assign pen_o  = pen_q;
    assign zone_o = zone_q;

endmodule

// File: rtl/sg_pin_guard.sv
// Hardware lock from the active-low protect pin, gated by the enable flag.
// While busy_i is high the lock is frozen at its value from the cycle before
// busy rose, so pin movement cannot disturb a running write.
module sg_pin_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic pen_i,
    input  logic wp_n_i,
    input  logic busy_i,
    output logic lock_o
);

    logic live_lock;
    logic lock_q;

    // Live lock: pin low counts only when the enable flag is set.
    always_comb live_lock = pen_i & ~wp_n_i;

    // Selected lock: frozen copy while busy, live value otherwise.
    always_comb lock_o = busy_i ? lock_q : live_lock;

    // Remember the selected lock so a busy period keeps the pre-busy value.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_o;
    end

endmodule

// File: rtl/sg_zone_decode.sv
// Decodes the two-bit zone selector against an address: none, upper quarter,
// upper half or whole space. Assumes ADDR_W >= 2; the zone edges are taken
// from the top one or two address bits, so they scale with ADDR_W.
module sg_zone_decode
    import sg_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  zone_e             zone_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);

    localparam int TOP = ADDR_W - 1;

    logic upper_half;
    logic upper_quarter;

    // Region membership from the most significant address bits.
    always_comb begin
        upper_half    = addr_i[TOP];
        upper_quarter = addr_i[TOP] & addr_i[TOP-1];
    end

    // Map the selector onto the matching region.
    always_comb begin
        unique case (zone_i)
            ZONE_NONE:    locked_o = 1'b0;
            ZONE_QUARTER: locked_o = upper_quarter;
            ZONE_HALF:    locked_o = upper_half;
            ZONE_ALL:     locked_o = 1'b1;
            default:      locked_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/status_guard.sv
// Status register write protector. Holds the status byte, decides whether a
// status write is accepted and whether an address sits in a protected zone.
// Assumes single-cycle command strobes from a decoder; non-volatile fields are
// plain registers with synchronous active-low reset.
module status_guard
    import sg_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              sr_wr_i,
    input  logic [STAT_W-1:0] sr_wdata_i,
    input  logic              busy_i,
    input  logic              wp_n_i,
    input  logic [ADDR_W-1:0] chk_addr_i,
    input  logic              wr_done_i,
    output logic [STAT_W-1:0] status_o,
    output logic              addr_locked_o,
    output logic              sr_wr_ok_o
);

    logic  wel;
    logic  pen;
    zone_e zone;
    logic  pin_lock;
    logic  sr_accept;
    logic  wel_drop;

    // Permission and accept qualification for status writes.
    always_comb begin
        sr_wr_ok_o = wel & ~pin_lock;
        sr_accept  = sr_wr_i & sr_wr_ok_o;
        wel_drop   = wel_clr_i | wr_done_i | sr_accept;
    end

    sg_enable_latch u_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (wel_set_i),
        .clr_i (wel_drop),
        .wel_o (wel)
    );

    sg_status_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (sr_accept),
        .wdata_i (sr_wdata_i),
        .pen_o   (pen),
        .zone_o  (zone)
    );

    sg_pin_guard u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .pen_i  (pen),
        .wp_n_i (wp_n_i),
        .busy_i (busy_i),
        .lock_o (pin_lock)
    );

    sg_zone_decode #(.ADDR_W(ADDR_W)) u_zone (
        .zone_i   (zone),
        .addr_i   (chk_addr_i),
        .locked_o (addr_locked_o)
    );

    // Readout byte, busy bit passed straight through.
    always_comb status_o = pack_status(pen, zone, wel, busy_i);

endmodule

// File: rtl/status_guard_chk.sv
// Property checker for status_guard, attached by bind. Observes ports only.
module status_guard_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wel_set_i,
    input logic              wel_clr_i,
    input logic              sr_wr_i,
    input logic              busy_i,
    input logic              wp_n_i,
    input logic              wr_done_i,
    input logic [7:0]        status_o,
    input logic              addr_locked_o,
    input logic              sr_wr_ok_o
);

    logic seen_q;

    // Marks that at least one post-reset cycle has passed for $past use.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);

    a_r2_busy_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] == busy_i);

    a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_set_i && !wel_clr_i && !wr_done_i && !sr_wr_i) |=> status_o[1]);

    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_i |=> !status_o[1]);

    a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done_i |=> !status_o[1]);

    a_r4_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_i && sr_wr_ok_o) |=> !status_o[1]);

    a_r6_zone_all: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] == 2'b11) |-> addr_locked_o);

    a_r6_zone_none: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] == 2'b00) |-> !addr_locked_o);

    a_r7_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[1] |-> !sr_wr_ok_o);

    a_r9_pin_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[7] && !busy_i) |-> (sr_wr_ok_o == status_o[1]));

    a_r8_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_i && !sr_wr_ok_o && !wel_set_i) |=> $stable(status_o[7:2]));

    a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && busy_i && $past(busy_i) && $stable(status_o[7:1]))
            |-> $stable(sr_wr_ok_o));

endmodule

bind status_guard status_guard_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wel_set_i     (wel_set_i),
    .wel_clr_i     (wel_clr_i),
    .sr_wr_i       (sr_wr_i),
    .busy_i        (busy_i),
    .wp_n_i        (wp_n_i),
    .wr_done_i     (wr_done_i),
    .status_o      (status_o),
    .addr_locked_o (addr_locked_o),
    .sr_wr_ok_o    (sr_wr_ok_o)
);

// File: tb/test_status_guard.sv
// Bench for status_guard: behavioural reference model compared every clock,
// plus directed checks on the requirement corner cases.
module test_status_guard;

    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wel_set, wel_clr, sr_wr, busy, wp_n, wr_done;
    logic [7:0]    wdata;
    logic [AW-1:0] addr;
    logic [7:0]    status;
    logic          locked, ok;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 0;

    // Reference model state
    bit  m_pen, m_wel, m_hold;
    int  m_zone;

    always #2 clk = ~clk;

    status_guard #(.ADDR_W(AW)) i_status_guard (
        .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set), .wel_clr_i(wel_clr),
        .sr_wr_i(sr_wr), .sr_wdata_i(wdata), .busy_i(busy), .wp_n_i(wp_n),
        .chk_addr_i(addr), .wr_done_i(wr_done), .status_o(status),
        .addr_locked_o(locked), .sr_wr_ok_o(ok)
    );

    function automatic bit f_lock_pin();
        if (busy) return m_hold;
        return m_pen && !wp_n;
    endfunction

    function automatic bit f_ok();
        return m_wel && !f_lock_pin();
    endfunction

    function automatic bit f_locked();
        int a = int'(addr);
        case (m_zone)
            0: return 1'b0;
            1: return a >= 1536;
            2: return a >= 1024;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] f_status();
        return {m_pen, 3'b000, m_zone[1:0], m_wel, busy};
    endfunction

    // Model update at each rising edge from the inputs present before it.
    always @(posedge clk) begin
        bit acc, hold_nx;
        if (!rst_n) begin
            m_pen = 0; m_wel = 0; m_hold = 0; m_zone = 0;
        end else begin
            acc     = sr_wr && f_ok();
            hold_nx = f_lock_pin();
            if (acc) begin
                m_pen  = wdata[7];
                m_zone = {30'd0, wdata[3:2]};
            end
            if (wel_clr || wr_done || acc) m_wel = 0;
            else if (wel_set)              m_wel = 1;
            m_hold = hold_nx;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model, then advance one clock.
    task automatic tick();
        #1;
        chk("R2 status byte", int'(status), int'(f_status()));
        chk("R6 zone lock",   int'(locked), int'(f_locked()));
        chk("R7 write ok",    int'(ok),     int'(f_ok()));
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wel_set = 0; wel_clr = 0; sr_wr = 0; wr_done = 0;
    endtask

    task automatic sr_write(input logic [7:0] v);
        sr_wr = 1; wdata = v; tick(); idle();
    endtask

    task automatic set_wel();
        wel_set = 1; tick(); idle();
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        rst_n = 0; idle(); busy = 0; wp_n = 1; wdata = 0; addr = 0;
        @(negedge clk); tick(); tick();
        rst_n = 1; #1;
        chk("R1 reset status", int'(status), 0);
        chk("R1 reset ok", int'(ok), 0);
        chk("R1 reset lock", int'(locked), 0);

        set_wel(); #1;
        chk("R3 set latch", int'(status), 8'h02);
        chk("R7 ok with latch", int'(ok), 1);

        sr_write(8'hFF); #1;
        chk("R5 loaded fields", int'(status), 8'h8C);
        chk("R4 accept clears latch", int'(status[1]), 0);
        addr = 11'h000; #1;
        chk("R6 all zone addr 0", int'(locked), 1);

        wp_n = 0; set_wel(); #1;
        chk("R7 pin lock blocks", int'(ok), 0);
        sr_write(8'h00); #1;
        chk("R8 rejected write", int'(status), 8'h8E);

        wp_n = 1; #1;
        chk("R7 pin high allows", int'(ok), 1);
        sr_write(8'h04); #1;
        chk("R5 quarter zone", int'(status), 8'h04);
        addr = 11'h5FF; #1;
        chk("R6 below quarter edge", int'(locked), 0);
        addr = 11'h600; #1;
        chk("R6 quarter edge", int'(locked), 1);

        wp_n = 0; set_wel(); #1;
        chk("R9 pin ignored, enable clear", int'(ok), 1);
        sr_write(8'h08); #1;
        chk("R9 write accepted with pin low", int'(status), 8'h08);
        addr = 11'h3FF; #1;
        chk("R6 below half edge", int'(locked), 0);
        addr = 11'h400; #1;
        chk("R6 half edge", int'(locked), 1);

        wel_set = 1; wel_clr = 1; tick(); idle(); #1;
        chk("R3 clear wins", int'(status[1]), 0);
        set_wel(); wr_done = 1; tick(); idle(); #1;
        chk("R4 done clears latch", int'(status[1]), 0);

        wp_n = 1; set_wel(); sr_write(8'h88); set_wel(); #1;
        chk("R5 enable flag set", int'(status), 8'h8A);
        busy = 1; tick();
        wp_n = 0; #1;
        chk("R10 frozen ok during busy", int'(ok), 1);
        chk("R2 busy readable", int'(status[0]), 1);
        tick(); tick();
        busy = 0; #1;
        chk("R10 lock returns after busy", int'(ok), 0);
        tick();

        for (int i = 0; i < 3000; i++) begin
            wel_set = ($urandom_range(0, 3) == 0);
            wel_clr = ($urandom_range(0, 15) == 0);
            sr_wr   = ($urandom_range(0, 4) == 0);
            wr_done = ($urandom_range(0, 15) == 0);
            wdata   = 8'($urandom);
            addr    = AW'($urandom);
            if ($urandom_range(0, 5) == 0) busy = ~busy;
            if ($urandom_range(0, 3) == 0) wp_n = ~wp_n;
            tick();
        end
        idle(); tick();
        finish_run();
    end

endmodule